// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block turns a single request (byte program, sector erase or whole-chip erase) into the series of command writes a 5 V byte-wide flash expects. It then watches the operation finish by polling the flash's status bit. Unlock addresses and command bytes are generated inside the block. Every transfer goes out on a simple bus-master port as one write or read strobe that is held until a separate bus controller acknowledges it. That controller owns the pin-level strobe timing.

After the last command write, the block waits a set number of cycles and reads the polled location. While the embedded algorithm runs, the flash returns the inverse of the final bit 7 value. Once the read bit 7 equals the expected value, the block pulses done. If the poll phase runs past a cycle budget, it pulses an error instead. Program and erase each have their own budget. Either way the block returns to idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: The request op code is 2'b01 for program, 2'b10 for sector erase and 2'b11 for chip erase. A program issues four writes, in order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the program data to the target address.
- R2: An erase issues six writes, in order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then a final write. For chip erase the final write is 10h@5555h. For sector erase it is 30h to the sector base, which keeps address bits 16:14 of the target and zeroes bits 13:0.
- R3: Only one of the write and read strobes is high at a time. A strobe, with its address and write data, holds steady until bus_ack_i is sampled high. Each acknowledged strobe is one transfer.
- R4: After the final command write is acknowledged, the block waits POLL_GAP cycles and then issues a read. It repeats this gap-then-read pattern until the operation completes. The read address is the target address for program and chip erase, and the sector base for sector erase.
- R5: Completion is a read whose bit 7 equals the expected value. For a program that is bit 7 of the program data; for an erase it is 1. On completion done_o pulses for one cycle with busy_o low. With k polls that return the inverted bit before the match, busy_o is high for 2·W + (k+1)·(POLL_GAP+2) cycles, where W is the number of writes and each transfer takes one acknowledge cycle.
- R6: If the poll phase lasts PROG_TMO_CYC cycles (program) or ERASE_TMO_CYC cycles (erase) without a match, err_o pulses for one cycle and the block returns to idle with no strobe. Busy is then high for 2·W plus the timeout value.
- R7: busy_o rises in the cycle after a request is accepted and stays high until the cycle in which done_o or err_o pulses.
- R8: A request made while busy_o is high, or with op code 2'b00, is ignored. It changes neither the transfer sequence nor the busy time.
- R9: After reset, busy_o, done_o, err_o and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled in idle |
| req_op_i | input | 2 | Operation code |
| req_addr_i | input | ADDR_W | Target byte or sector address |
| req_data_i | input | DATA_W | Program data |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_wr_o | output | 1 | Write strobe, held until acknowledged |
| bus_rd_o | output | 1 | Read strobe, held until acknowledged |
| bus_ack_i | input | 1 | Transfer acknowledge, read data valid |
| bus_rdata_i | input | DATA_W | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |

## Verification
The bound checker watches the port-level rules on every cycle:
- the two strobes never overlap, and a strobe holds steady until acknowledged;
- every operation opens with the AAh@5555h unlock;
- strobes appear only while busy;
- done and error never coincide, and each closes a busy period;
- nothing is driven after an error.

Only the bench scenarios can show the rest: the full ordered write sequence per op code and per sector, the poll address, the exact busy length as the number of inverted polls changes, the timeouts for both operation classes, and that requests are ignored while busy.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_CHIP = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_GAP,
    ST_READ
  } seq_state_e;

  localparam int STEP_W = 3;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
endpackage

// File: rtl/seq_cmd_table.sv
module seq_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  seq_op_e           op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [DATA_W-1:0] tgt_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  localparam int OFS_W = ADDR_W - SECT_W;
  localparam logic [STEP_W-1:0] PROG_LAST  = STEP_W'(3);
  localparam logic [STEP_W-1:0] ERASE_LAST = STEP_W'(5);

  logic [ADDR_W-1:0] ua_a, ua_b, sect_base;
  logic              is_prog;

  assign ua_a      = ADDR_W'(UNLK_ADDR_A);
  assign ua_b      = ADDR_W'(UNLK_ADDR_B);
  assign sect_base = {tgt_addr_i[ADDR_W-1 -: SECT_W], {OFS_W{1'b0}}};
  assign is_prog   = (op_i == OP_PROG);

  always_comb begin
    addr_o = ua_a;
    data_o = DATA_W'(CMD_KEY_A);
    unique case (step_i)
      3'd0: begin addr_o = ua_a; data_o = DATA_W'(CMD_KEY_A); end
      3'd1: begin addr_o = ua_b; data_o = DATA_W'(CMD_KEY_B); end
      3'd2: begin
        addr_o = ua_a;
        data_o = is_prog ? DATA_W'(CMD_PROG) : DATA_W'(CMD_ERASE);
      end
      3'd3: begin
        addr_o = is_prog ? tgt_addr_i : ua_a;
        data_o = is_prog ? tgt_data_i : DATA_W'(CMD_KEY_A);
      end
      3'd4: begin addr_o = ua_b; data_o = DATA_W'(CMD_KEY_B); end
      default: begin
        addr_o = (op_i == OP_CHIP) ? ua_a : sect_base;
        data_o = (op_i == OP_CHIP) ? DATA_W'(CMD_CHIP) : DATA_W'(CMD_SECTOR);
      end
    endcase
    last_o = is_prog ? (step_i == PROG_LAST) : (step_i == ERASE_LAST);
  end
endmodule

// File: rtl/seq_poll_eval.sv
module seq_poll_eval
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  seq_op_e           op_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [DATA_W-1:0] tgt_data_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] poll_addr_o,
  output logic              match_o
);
  localparam int OFS_W = ADDR_W - SECT_W;

  logic exp_bit;

  // erased cells read as ones; program polls for the written MSB
  assign exp_bit     = (op_i == OP_PROG) ? tgt_data_i[DATA_W-1] : 1'b1;
  assign match_o     = (rdata_i[DATA_W-1] == exp_bit);
  assign poll_addr_o = (op_i == OP_SECT) ? {tgt_addr_i[ADDR_W-1 -: SECT_W], {OFS_W{1'b0}}}
                                         : tgt_addr_i;
endmodule

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int POLL_GAP      = 16,
  parameter int PROG_TMO_CYC  = 8192,
  parameter int ERASE_TMO_CYC = 1000000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic gap_run_i,
  input  logic poll_run_i,
  input  logic is_prog_i,
  output logic gap_done_o,
  output logic tmo_hit_o
);
  localparam int TMO_MAX = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
  localparam int TMO_W   = $clog2(TMO_MAX + 1);
  localparam int GAP_W   = $clog2(POLL_GAP + 1);

  localparam logic [TMO_W-1:0] PROG_LIM  = TMO_W'(PROG_TMO_CYC - 1);
  localparam logic [TMO_W-1:0] ERASE_LIM = TMO_W'(ERASE_TMO_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_LIM   = GAP_W'(POLL_GAP - 1);

  logic [GAP_W-1:0] gap_q;
  logic [TMO_W-1:0] tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      tmo_q <= '0;
    end else begin
      gap_q <= gap_run_i ? gap_q + GAP_W'(1) : '0;
      if (clear_i)         tmo_q <= '0;
      else if (poll_run_i) tmo_q <= tmo_q + TMO_W'(1);
    end
  end

  assign gap_done_o = gap_run_i && (gap_q == GAP_LIM);
  assign tmo_hit_o  = poll_run_i && (tmo_q == (is_prog_i ? PROG_LIM : ERASE_LIM));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int SECT_W        = 3,
  parameter int POLL_GAP      = 16,
  parameter int PROG_TMO_CYC  = 8192,
  parameter int ERASE_TMO_CYC = 1000000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e        state_q;
  seq_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q, err_q;

  logic [ADDR_W-1:0] tbl_addr, poll_addr;
  logic [DATA_W-1:0] tbl_data;
  logic              tbl_last, poll_match, gap_done, tmo_hit;
  logic              in_write, in_gap, in_read;
  seq_op_e           req_op;

  assign req_op   = seq_op_e'(req_op_i);
  assign in_write = (state_q == ST_WRITE);
  assign in_gap   = (state_q == ST_GAP);
  assign in_read  = (state_q == ST_READ);

  seq_cmd_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_table (
    .op_i       (op_q),
    .step_i     (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (tbl_addr),
    .data_o     (tbl_data),
    .last_o     (tbl_last)
  );

  seq_poll_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_eval (
    .op_i        (op_q),
    .tgt_addr_i  (addr_q),
    .tgt_data_i  (data_q),
    .rdata_i     (bus_rdata_i),
    .poll_addr_o (poll_addr),
    .match_o     (poll_match)
  );

  seq_poll_timer #(
    .POLL_GAP     (POLL_GAP),
    .PROG_TMO_CYC (PROG_TMO_CYC),
    .ERASE_TMO_CYC(ERASE_TMO_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (in_write),
    .gap_run_i  (in_gap),
    .poll_run_i (in_gap || in_read),
    .is_prog_i  (op_q == OP_PROG),
    .gap_done_o (gap_done),
    .tmo_hit_o  (tmo_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i && req_op != OP_NONE) begin
            op_q    <= req_op;
            addr_q  <= req_addr_i;
            data_q  <= req_data_i;
            step_q  <= '0;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (bus_ack_i) begin
            if (tbl_last) state_q <= ST_GAP;
            else          step_q  <= step_q + STEP_W'(1);
          end
        end
        ST_GAP: begin
          if (tmo_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (gap_done) begin
            state_q <= ST_READ;
          end
        end
        default: begin
          // a matching read wins over a coincident timeout
          if (bus_ack_i && poll_match) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (tmo_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (bus_ack_i) begin
            state_q <= ST_GAP;
          end
        end
      endcase
    end
  end

  assign bus_wr_o    = in_write;
  assign bus_rd_o    = in_read;
  assign bus_addr_o  = in_write ? tbl_addr : poll_addr;
  assign bus_wdata_o = in_write ? tbl_data : '0;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_wr_o,
  input logic              bus_rd_o,
  input logic              bus_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  // R1 and R2 both open with the same unlock write
  a_r1_first_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> bus_wr_o && bus_addr_o == ADDR_W'(16'h5555) && bus_wdata_o == DATA_W'(8'hAA));

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));

  a_r3_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o || bus_rd_o) && !bus_ack_i |=>
      err_o || (bus_wr_o == $past(bus_wr_o) && bus_rd_o == $past(bus_rd_o) &&
                $stable(bus_addr_o) && $stable(bus_wdata_o)));

  a_r7_strobe_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o || bus_rd_o) |-> busy_o);

  a_r5_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r5_end_closes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o && $past(busy_o));

  a_r6_quiet_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !bus_wr_o && !bus_rd_o);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_wr_o    (bus_wr_o),
  .bus_rd_o    (bus_rd_o),
  .bus_ack_i   (bus_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int GAP = 4;
  localparam int PTMO = 40;
  localparam int ETMO = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_wr, bus_rd, busy, done, err;
  logic          ack;
  logic [DW-1:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit wd_hit = 0;

  // flash model state
  int            busy_reads = 0;
  int            reads_served = 0;
  int            n_wr = 0;
  int            rd_bad = 0;
  logic [DW-1:0] true_val = '0;
  logic [AW-1:0] exp_poll = '0;
  logic [AW-1:0] wr_a [0:7];
  logic [DW-1:0] wr_d [0:7];

  always #2 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SECT_W(3), .POLL_GAP(GAP),
    .PROG_TMO_CYC(PTMO), .ERASE_TMO_CYC(ETMO)
  ) u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_wr_o(bus_wr), .bus_rd_o(bus_rd),
    .bus_ack_i(ack), .bus_rdata_i(rdata), .busy_o(busy), .done_o(done), .err_o(err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= (bus_wr || bus_rd) && !ack;
      if (bus_rd && !ack)
        rdata <= (reads_served < busy_reads) ? {~true_val[7], 7'h15} : true_val;
      if (ack && bus_wr) begin
        if (n_wr < 8) begin
          wr_a[n_wr] <= bus_addr;
          wr_d[n_wr] <= bus_wdata;
        end
        n_wr <= n_wr + 1;
      end
      if (ack && bus_rd) begin
        reads_served <= reads_served + 1;
        if (bus_addr != exp_poll) rd_bad <= rd_bad + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_write(input int op, input int i, input logic [AW-1:0] a,
                                    input logic [DW-1:0] d, output logic [AW-1:0] ea,
                                    output logic [DW-1:0] ed);
    case (i)
      0: begin ea = 17'h05555; ed = 8'hAA; end
      1: begin ea = 17'h02AAA; ed = 8'h55; end
      2: begin ea = 17'h05555; ed = (op == 1) ? 8'hA0 : 8'h80; end
      3: begin ea = (op == 1) ? a : 17'h05555; ed = (op == 1) ? d : 8'hAA; end
      4: begin ea = 17'h02AAA; ed = 8'h55; end
      default: begin
        ea = (op == 3) ? 17'h05555 : {a[16:14], 14'h0};
        ed = (op == 3) ? 8'h10 : 8'h30;
      end
    endcase
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int k, input bit inject);
    int nw, cyc, exp_cyc;
    bit expect_err;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    string req;
    @(negedge clk);
    nw = (op == 1) ? 4 : 6;
    req = (op == 1) ? "R1" : "R2";
    expect_err = (k > 100);
    busy_reads = k;
    reads_served = 0;
    n_wr = 0;
    rd_bad = 0;
    true_val = (op == 1) ? d : 8'hFF;
    exp_poll = (op == 2) ? {a[16:14], 14'h0} : a;
    req_valid = 1'b1;
    req_op = 2'(op);
    req_addr = a;
    req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!(done || err) && cyc < 3000) begin
      if (busy) cyc++;
      if (inject && cyc == 3) begin
        req_valid = 1'b1; req_op = 2'b11; req_addr = 17'h1ABCD; req_data = 8'h33;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (expect_err)
      exp_cyc = 2 * nw + ((op == 1) ? PTMO : ETMO);
    else
      exp_cyc = 2 * nw + (k + 1) * (GAP + 2);
    chk(expect_err ? (err && !done) : (done && !err), expect_err ? "R6" : "R5",
        "end pulse", {done, err}, expect_err ? 1 : 2);
    chk(!busy, "R7", "busy low at end", busy, 0);
    chk(cyc == exp_cyc, expect_err ? "R6" : "R5", "busy cycles", cyc, exp_cyc);
    chk(n_wr == nw, req, "write count", n_wr, nw);
    for (int i = 0; i < nw && i < 8; i++) begin
      exp_write(op, i, a, d, ea, ed);
      chk(wr_a[i] == ea, req, $sformatf("write %0d addr", i), wr_a[i], ea);
      chk(wr_d[i] == ed, req, $sformatf("write %0d data", i), wr_d[i], ed);
    end
    chk(rd_bad == 0, "R4", "poll address mismatches", rd_bad, 0);
    if (!expect_err) chk(reads_served == k + 1, "R4", "poll reads", reads_served, k + 1);
    @(negedge clk);
    chk(!done && !err, "R5", "pulse is one cycle", {done, err}, 0);
    chk(!bus_wr && !bus_rd && !busy, "R6", "idle after end", {bus_wr, bus_rd, busy}, 0);
  endtask

  task automatic run_all();
    logic [AW-1:0] addrs [0:3];
    logic [DW-1:0] datas [0:3];
    addrs[0] = 17'h00000; addrs[1] = 17'h1FFFF; addrs[2] = 17'h0C123; addrs[3] = 17'h14ABC;
    datas[0] = 8'h00; datas[1] = 8'hFF; datas[2] = 8'h5A; datas[3] = 8'h80;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !err && !bus_wr && !bus_rd, "R9", "reset state",
        {busy, done, err, bus_wr, bus_rd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_wr && !bus_rd, "R9", "idle after reset", {busy, bus_wr, bus_rd}, 0);
    // R8 op code 00 ignored in idle
    n_wr = 0;
    req_valid = 1'b1; req_op = 2'b00; req_addr = 17'h05555;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && n_wr == 0, "R8", "null op ignored", {busy, 4'(n_wr)}, 0);
    // R1 program sweep over addresses, data and poll counts
    for (int ai = 0; ai < 4; ai++)
      for (int di = 0; di < 4; di++)
        for (int k = 0; k < 4; k++)
          run_op(1, addrs[ai], datas[di], k, 1'b0);
    // R2 sector erase over every sector, chip erase over addresses
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        run_op(2, {3'(s), 14'h2B7} ^ addrs[k], 8'h00, k, 1'b0);
    for (int ai = 0; ai < 4; ai++)
      for (int k = 0; k < 4; k++)
        run_op(3, addrs[ai], 8'h00, k, 1'b0);
    // R6 timeouts for each class
    run_op(1, 17'h0A5A5, 8'h7E, 1000, 1'b0);
    run_op(1, 17'h1F00F, 8'h81, 1000, 1'b0);
    run_op(2, 17'h16000, 8'h00, 1000, 1'b0);
    run_op(3, 17'h00001, 8'h00, 1000, 1'b0);
    // R8 request while busy ignored
    run_op(1, 17'h03C3C, 8'hC3, 2, 1'b1);
    run_op(2, 17'h0E000, 8'h00, 1, 1'b1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule